// File: doc/BRIEF.md
# Uncorrectable Error Mask and First-Error Logger

This block tracks uncorrectable link-layer and transaction-layer error events for a single switch port. Each event arrives as a one-cycle pulse on its own bit of an event vector. The event sets a sticky status bit in every case. A parallel mask register decides whether that event also takes part in logging and reporting. An unmasked event raises a single-cycle report request toward the upstream message logic. If the first-error pointer is free, the event also loads the pointer with its bit index. A masked event only sets its status bit.

Software reaches three registers through a simple read/write port. The status register is write-1-to-clear. The mask register is read/write only where the port can actually produce the error. The control register holds the first-error pointer and is read-only. Two synchronous, active-high resets are provided. A cold reset clears every sticky bit. A warm reset preserves all sticky state, and while it is asserted it also blocks events and register writes.

Top module: `uerr_log_top`

## Requirements
- R1: Mask bits 4 (data-link protocol), 5 (surprise down), 12 (poisoned packet) and 13 (flow-control protocol) are read/write: writing 0xFFFFFFFF to the mask register (address 1) reads back 0x00003030, and writing 0 reads back 0.
- R2: Bits 0, 3:1, 11:6 and 31:16 of the status register (address 0) and of the mask register read as zero, and writes to them have no effect. Events on these bit positions set nothing.
- R3: Mask bit 14 (completion timeout) and mask bit 15 (completer abort) always read 0 and cannot be set.
- R4: An event on bit 4, 5, 12, 13, 14 or 15 sets the matching status bit at the next clock edge, whether or not its mask bit is set.
- R5: A masked event raises no report request and leaves the first-error pointer unchanged.
- R6: An unmasked event drives report_o high for exactly the one cycle after the event's clock edge. This holds even when its status bit is already set.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If an event and a clear hit the same bit in the same cycle, the bit stays set.
- R8: The control register (address 2) shows the first-error pointer in bits 4:0 and ignores writes. When the pointer is free it loads the bit index of an unmasked event. If several unmasked events arrive in one cycle, the lowest index wins.
- R9: The pointer is held while the status bit it indicates is still set. Clearing that bit frees the pointer. A clear of the indicated bit and a new unmasked event in the same cycle load the new index.
- R10: Cold reset (rst_cold) clears the status register, the mask register and the pointer, and holds report_o low.
- R11: While warm reset (rst_warm) is asserted, the status, mask and pointer values are kept, events and register writes are ignored, and report_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_cold | input | 1 | Synchronous cold reset, clears sticky state |
| rst_warm | input | 1 | Synchronous warm reset, keeps sticky state |
| evt_i | input | 16 | One-cycle error event pulses, one per status bit position |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 status, 1 mask, 2 control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| report_o | output | 1 | Single-cycle upstream error report request |

## Verification
Two functions of the block can act in the same cycle: a software write-1-to-clear on the status register, and the arrival of a new error event. The bench drives both in one cycle in two ways. First, it clears the bit the pointer indicates while a different unmasked event arrives; the pointer must then load the new index. Second, it clears a bit while an event arrives on that same bit; the bit must stay set. After each case it reads the status and control registers back and compares them with values computed from the requirements.

// File: rtl/uerr_pkg.sv
package uerr_pkg;

    localparam int REG_W  = 32;
    localparam int EVT_W  = 16;
    localparam int PTR_W  = 5;
    localparam int ADDR_W = 2;

    localparam int B_DLINK   = 4;
    localparam int B_SDOWN   = 5;
    localparam int B_POISON  = 12;
    localparam int B_FCTRL   = 13;
    localparam int B_CMPLTO  = 14;
    localparam int B_CMPLABT = 15;

    // Positions that carry a real status bit
    localparam logic [EVT_W-1:0] IMPL_BITS =
        EVT_W'((1 << B_DLINK) | (1 << B_SDOWN) | (1 << B_POISON) |
               (1 << B_FCTRL) | (1 << B_CMPLTO) | (1 << B_CMPLABT));

    // Positions whose mask bit software may set
    localparam logic [EVT_W-1:0] MASK_RW_BITS =
        EVT_W'((1 << B_DLINK) | (1 << B_SDOWN) | (1 << B_POISON) |
               (1 << B_FCTRL));

    typedef enum logic [ADDR_W-1:0] {
        RSEL_STATUS = 2'd0,
        RSEL_MASK   = 2'd1,
        RSEL_CTRL   = 2'd2,
        RSEL_NONE   = 2'd3
    } rsel_e;

    typedef struct packed {
        logic             wr_status;
        logic             wr_mask;
        logic [EVT_W-1:0] data;
    } reg_cmd_t;

    // Index of the least significant set bit; 0 when none
    function automatic logic [PTR_W-1:0] lowest_idx(input logic [EVT_W-1:0] v);
        logic [PTR_W-1:0] idx;
        logic             found;
        idx   = '0;
        found = 1'b0;
        for (int i = 0; i < EVT_W; i++) begin
            if (v[i] && !found) begin
                idx   = PTR_W'(i);
                found = 1'b1;
            end
        end
        return idx;
    endfunction

endpackage

// File: rtl/uerr_status_reg.sv
module uerr_status_reg
    import uerr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_cold,
    input  logic             accept,
    input  logic [EVT_W-1:0] evt,
    input  logic [EVT_W-1:0] clr,
    output logic [EVT_W-1:0] status_q,
    output logic [EVT_W-1:0] status_kept
);

    logic [EVT_W-1:0] set_vec;

    always_comb begin
        status_kept = status_q & ~clr;
        set_vec     = accept ? (evt & IMPL_BITS) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst_cold) begin
            status_q <= '0;
        end else if (accept) begin
            status_q <= status_kept | set_vec;
        end
    end

endmodule

// File: rtl/uerr_mask_reg.sv
module uerr_mask_reg
    import uerr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_cold,
    input  logic             wr_en,
    input  logic [EVT_W-1:0] wdata,
    output logic [EVT_W-1:0] mask_q
);

    for (genvar i = 0; i < EVT_W; i++) begin : g_bit
        if (MASK_RW_BITS[i]) begin : g_rw
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst_cold) begin
                    bit_q <= 1'b0;
                end else if (wr_en) begin
                    bit_q <= wdata[i];
                end
            end
            assign mask_q[i] = bit_q;
        end else begin : g_ro
            assign mask_q[i] = 1'b0;
        end
    end

endmodule

// File: rtl/uerr_first_ptr.sv
module uerr_first_ptr
    import uerr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_cold,
    input  logic             accept,
    input  logic [EVT_W-1:0] status_kept,
    input  logic [EVT_W-1:0] unmasked,
    output logic [PTR_W-1:0] ptr_q
);

    logic free;
    logic load;

    always_comb begin
        free = !status_kept[ptr_q[3:0]];
        load = accept && free && (|unmasked);
    end

    always_ff @(posedge clk) begin
        if (rst_cold) begin
            ptr_q <= '0;
        end else if (load) begin
            ptr_q <= lowest_idx(unmasked);
        end
    end

endmodule

// File: rtl/uerr_log_top.sv
module uerr_log_top
    import uerr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_cold,
    input  logic              rst_warm,
    input  logic [EVT_W-1:0]  evt_i,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              report_o
);

    logic             accept;
    reg_cmd_t         cmd;
    logic [EVT_W-1:0] clr_vec;
    logic [EVT_W-1:0] status_q;
    logic [EVT_W-1:0] status_kept;
    logic [EVT_W-1:0] mask_q;
    logic [EVT_W-1:0] unmasked;
    logic [PTR_W-1:0] ptr_q;
    logic             report_q;

    always_comb begin
        accept        = !rst_warm;
        cmd.wr_status = accept && reg_wr && (rsel_e'(reg_addr) == RSEL_STATUS);
        cmd.wr_mask   = accept && reg_wr && (rsel_e'(reg_addr) == RSEL_MASK);
        cmd.data      = reg_wdata[EVT_W-1:0];
        clr_vec       = cmd.wr_status ? cmd.data : '0;
        unmasked      = evt_i & IMPL_BITS & ~mask_q;
    end

    uerr_status_reg u_status (
        .clk         (clk),
        .rst_cold    (rst_cold),
        .accept      (accept),
        .evt         (evt_i),
        .clr         (clr_vec),
        .status_q    (status_q),
        .status_kept (status_kept)
    );

    uerr_mask_reg u_mask (
        .clk      (clk),
        .rst_cold (rst_cold),
        .wr_en    (cmd.wr_mask),
        .wdata    (cmd.data),
        .mask_q   (mask_q)
    );

    uerr_first_ptr u_ptr (
        .clk         (clk),
        .rst_cold    (rst_cold),
        .accept      (accept),
        .status_kept (status_kept),
        .unmasked    (unmasked),
        .ptr_q       (ptr_q)
    );

    always_ff @(posedge clk) begin
        if (rst_cold || rst_warm) begin
            report_q <= 1'b0;
        end else begin
            report_q <= |unmasked;
        end
    end

    assign report_o = report_q;

    always_comb begin
        case (rsel_e'(reg_addr))
            RSEL_STATUS: reg_rdata = REG_W'(status_q);
            RSEL_MASK:   reg_rdata = REG_W'(mask_q);
            RSEL_CTRL:   reg_rdata = REG_W'(ptr_q);
            default:     reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/uerr_log_chk.sv
module uerr_log_chk
    import uerr_pkg::*;
(
    input logic              clk,
    input logic              rst_cold,
    input logic              rst_warm,
    input logic [EVT_W-1:0]  evt_i,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [REG_W-1:0]  reg_rdata,
    input logic              report_o,
    input logic [EVT_W-1:0]  status_q,
    input logic [EVT_W-1:0]  mask_q,
    input logic [PTR_W-1:0]  ptr_q
);

    logic [EVT_W-1:0] live_evt;
    logic             ptr_clr_hit;

    always_comb begin
        live_evt    = evt_i & IMPL_BITS;
        ptr_clr_hit = reg_wr && (reg_addr == 2'd0) && reg_wdata[ptr_q[3:0]];
    end

    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (rst_cold)
        (reg_addr != 2'd2) |-> ((reg_rdata & ~REG_W'(IMPL_BITS)) == '0)); // R2

    AST_HARDWIRED_MASK_ZERO: assert property (@(posedge clk) disable iff (rst_cold)
        (reg_addr == 2'd1) |-> (reg_rdata[15:14] == 2'b00)); // R3

    AST_EVT_SETS_STATUS: assert property (@(posedge clk) disable iff (rst_cold)
        (!rst_warm && (|live_evt)) |=> ((status_q & $past(live_evt)) == $past(live_evt))); // R4

    AST_NO_REPORT_MASKED: assert property (@(posedge clk) disable iff (rst_cold)
        (!(|(live_evt & ~mask_q))) |=> !report_o); // R5

    AST_REPORT_UNMASKED: assert property (@(posedge clk) disable iff (rst_cold || rst_warm)
        (|(live_evt & ~mask_q)) |=> report_o); // R6

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst_cold)
        (status_q[ptr_q[3:0]] && !ptr_clr_hit) |=> $stable(ptr_q)); // R9

    AST_WARM_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst_cold)
        rst_warm |=> ($stable(status_q) && $stable(mask_q) && $stable(ptr_q))); // R11

    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst_cold)
        !ptr_q[4]); // R8

endmodule

bind uerr_log_top uerr_log_chk chk_i (
    .clk       (clk),
    .rst_cold  (rst_cold),
    .rst_warm  (rst_warm),
    .evt_i     (evt_i),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .report_o  (report_o),
    .status_q  (status_q),
    .mask_q    (mask_q),
    .ptr_q     (ptr_q)
);

// File: tb/uerr_log_top_tb.sv
module uerr_log_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_cold;
    logic        rst_warm;
    logic [15:0] evt_i;
    logic        reg_wr;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        report_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    uerr_log_top dut_i (
        .clk       (clk),
        .rst_cold  (rst_cold),
        .rst_warm  (rst_warm),
        .evt_i     (evt_i),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .report_o  (report_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // One clock: drive at negedge, return at following negedge
    task automatic step(input logic wr, input logic [1:0] addr,
                        input logic [31:0] wd, input logic [15:0] ev);
        reg_wr    = wr;
        reg_addr  = addr;
        reg_wdata = wd;
        evt_i     = ev;
        @(negedge clk);
        reg_wr = 1'b0;
        evt_i  = '0;
    endtask

    task automatic rd(input logic [1:0] addr, output logic [31:0] val);
        reg_addr = addr;
        #1;
        val = reg_rdata;
    endtask

    task automatic cold_reset();
        rst_cold = 1'b1;
        step(1'b0, 2'd0, '0, '0);
        step(1'b0, 2'd0, '0, '0);
        rst_cold = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        cold_reset();
        rd(2'd0, v); check("R10 status after cold reset", v, 32'h0);
        rd(2'd1, v); check("R10 mask after cold reset", v, 32'h0);
        rd(2'd2, v); check("R10 pointer after cold reset", v, 32'h0);
        check("R10 report low after cold reset", {31'b0, report_o}, 32'h0);
    endtask

    task automatic t_mask_access();
        logic [31:0] v;
        step(1'b1, 2'd1, 32'hFFFF_FFFF, '0);
        rd(2'd1, v); check("R1 R2 R3 mask all-ones readback", v, 32'h0000_3030);
        step(1'b1, 2'd2, 32'h0000_001F, '0);
        rd(2'd2, v); check("R8 control ignores write", v, 32'h0);
        step(1'b1, 2'd1, 32'h0, '0);
        rd(2'd1, v); check("R1 mask zero readback", v, 32'h0);
    endtask

    task automatic t_all_events();
        logic [31:0] v;
        step(1'b0, 2'd0, '0, 16'hFFFF);
        check("R6 report after unmasked events", {31'b0, report_o}, 32'h1);
        rd(2'd0, v); check("R2 R4 status from all-ones events", v, 32'h0000_F030);
        rd(2'd2, v); check("R8 lowest index wins", v, 32'd4);
        step(1'b0, 2'd0, '0, '0);
        check("R6 report lasts one cycle", {31'b0, report_o}, 32'h0);
        step(1'b1, 2'd0, 32'h0000_0000, '0);
        rd(2'd0, v); check("R7 writing zero keeps status", v, 32'h0000_F030);
        step(1'b1, 2'd0, 32'hFFFF_FFFF, '0);
        rd(2'd0, v); check("R7 write-1 clears status", v, 32'h0);
    endtask

    task automatic t_masked_event();
        logic [31:0] v;
        step(1'b1, 2'd1, 32'h0000_1000, '0);
        step(1'b0, 2'd0, '0, 16'h1000);
        check("R5 masked event gives no report", {31'b0, report_o}, 32'h0);
        rd(2'd0, v); check("R4 masked event sets status", v, 32'h0000_1000);
        rd(2'd2, v); check("R5 masked event keeps pointer", v, 32'd4);
        step(1'b0, 2'd0, '0, 16'h2000);
        check("R6 unmasked event report", {31'b0, report_o}, 32'h1);
        rd(2'd2, v); check("R8 free pointer captures 13", v, 32'd13);
    endtask

    task automatic t_pointer_hold();
        logic [31:0] v;
        step(1'b0, 2'd0, '0, 16'h0020);
        check("R6 report for bit 5", {31'b0, report_o}, 32'h1);
        rd(2'd2, v); check("R9 pointer held while bit 13 set", v, 32'd13);
        step(1'b0, 2'd0, '0, 16'h2000);
        check("R6 report with status already set", {31'b0, report_o}, 32'h1);
        step(1'b1, 2'd0, 32'h0000_0020, '0);
        rd(2'd0, v); check("R7 clear bit 5 only", v, 32'h0000_3000);
    endtask

    task automatic t_same_cycle();
        logic [31:0] v;
        // clear pointed bit 13 while bit 15 arrives
        step(1'b1, 2'd0, 32'h0000_2000, 16'h8000);
        rd(2'd2, v); check("R9 clear and new event load new index", v, 32'd15);
        rd(2'd0, v); check("R9 status after clear plus event", v, 32'h0000_9000);
        // clear bit 15 while bit 15 arrives
        step(1'b1, 2'd0, 32'h0000_8000, 16'h8000);
        rd(2'd0, v); check("R7 event beats clear on same bit", v, 32'h0000_9000);
        rd(2'd2, v); check("R9 pointer stays 15", v, 32'd15);
    endtask

    task automatic t_simultaneous();
        logic [31:0] v;
        step(1'b1, 2'd0, 32'hFFFF_FFFF, '0);
        step(1'b0, 2'd0, '0, 16'h9010);
        rd(2'd2, v); check("R8 lowest of 4 and 15 (12 masked)", v, 32'd4);
        rd(2'd0, v); check("R4 status from three events", v, 32'h0000_9010);
    endtask

    task automatic t_warm_reset();
        logic [31:0] v;
        rst_warm = 1'b1;
        step(1'b1, 2'd1, 32'h0, 16'h0020);
        step(1'b1, 2'd0, 32'hFFFF_FFFF, 16'h2000);
        check("R11 no report during warm reset", {31'b0, report_o}, 32'h0);
        rst_warm = 1'b0;
        rd(2'd0, v); check("R11 status kept", v, 32'h0000_9010);
        rd(2'd1, v); check("R11 mask kept", v, 32'h0000_1000);
        rd(2'd2, v); check("R11 pointer kept", v, 32'd4);
        cold_reset();
        rd(2'd0, v); check("R10 cold reset clears status", v, 32'h0);
        rd(2'd1, v); check("R10 cold reset clears mask", v, 32'h0);
        rd(2'd2, v); check("R10 cold reset clears pointer", v, 32'h0);
    endtask

    initial begin
        rst_cold  = 1'b1;
        rst_warm  = 1'b0;
        evt_i     = '0;
        reg_wr    = 1'b0;
        reg_addr  = '0;
        reg_wdata = '0;
        @(negedge clk);
        t_reset_state();
        t_mask_access();
        t_all_events();
        t_masked_event();
        t_pointer_hold();
        t_same_cycle();
        t_simultaneous();
        t_warm_reset();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule